// File: doc/BRIEF.md
# Two-Road Junction Light Controller

The block runs the lights at a crossing where a busy major road meets a quiet minor road. By default the major road has green and the minor road has red. A vehicle sensor on the minor road asks for service. When the sensor is seen, the controller gives the minor road green for a fixed dwell and then hands green back to the major road. Only green and red are driven.

The block has two parts. A two-phase sequencer decides which road has green. A separate binary interval timer measures the dwell. The sequencer requests an interval from the timer and waits for its done pulse, so the dwell length never shows up as extra controller states.

A parameter chooses how the timer is driven:
- In start-pulse mode, the sequencer sends a one-cycle start and the timer runs by itself.
- In hold-enable mode, the sequencer holds an enable for the whole minor-green phase. The timer counts only while that enable is high.

Both modes give the same light sequence at the ports. The dwell is `2**CNT_W` cycles, which is 256 by default.

Top module: `tlc_junction`

## Requirements
- R1: A synchronous reset puts the junction in major-green. The timer is cleared, and minor-green does not appear until the sensor is seen after reset.
- R2: Each lamp output carries a 2-bit code: green is 2'b10 and red is 2'b01. In every cycle exactly one road shows green.
- R3: When the sensor is high at a clock edge during major-green, the minor road shows green from that edge on. The major road shows red from the same edge.
- R4: While the sensor stays low, major-green is held indefinitely.
- R5: A minor-green phase lasts exactly `2**CNT_W` clock cycles. After it, major-green returns and the timer is idle again.
- R6: A sensor asserted at any point during minor-green has no effect. The phase keeps its exact length.
- R7: If the sensor is still high when major-green returns, major-green lasts exactly one cycle and then a new minor-green phase of full length starts.
- R8: Start-pulse mode and hold-enable mode produce cycle-for-cycle identical lamp outputs for the same sensor input.
- R9: A reset during minor-green returns the junction to major-green. The next served request gets a full-length minor-green phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_waiting | input | 1 | Vehicle sensor on the minor road |
| major_lamp | output | 2 | Major-road lamp code (10 green, 01 red) |
| minor_lamp | output | 2 | Minor-road lamp code (10 green, 01 red) |

## Verification
The bench builds two copies of the junction with `CNT_W` set to 4, one copy in each timer mode, and drives both with the same sensor input. A 16-cycle dwell lets many complete phases fit into a short run. It also brings the timer's terminal count, its wrap back to idle, and a sensor held across the whole phase within reach. With both modes side by side, every sampled cycle also compares the two copies against each other.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic {
        PH_MAJOR = 1'b0,
        PH_MINOR = 1'b1
    } phase_t;

    localparam logic [1:0] LAMP_GREEN = 2'b10;
    localparam logic [1:0] LAMP_RED   = 2'b01;

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int CNT_W       = 8,
    parameter bit HOLD_ENABLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic timed
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    generate
        if (HOLD_ENABLE) begin : g_hold
            // Counts only while the request level is held; clears otherwise.
            always_comb begin
                tmr_d.busy = req;
                tmr_d.cnt  = req ? tmr_q.cnt + 1'b1 : '0;
                timed      = req && tmr_q.busy && (tmr_q.cnt == LAST);
            end
        end else begin : g_pulse
            // A one-cycle start launches a free-running interval.
            always_comb begin
                tmr_d = tmr_q;
                if (!tmr_q.busy) begin
                    tmr_d.cnt = '0;
                    if (req) tmr_d.busy = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                    if (tmr_q.cnt == LAST) tmr_d.busy = 1'b0;
                end
                timed = tmr_q.busy && (tmr_q.cnt == LAST);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    AST_TIMED_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        timed |=> !timed); // R5
    AST_TIMED_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        timed |=> (tmr_q.cnt == '0)); // R5

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
#(
    parameter bit HOLD_ENABLE = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   car,
    input  logic   timed,
    output logic   req,
    output phase_t phase
);
    typedef struct packed {
        phase_t phase;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_MAJOR: if (car)   seq_d.phase = PH_MINOR;
            PH_MINOR: if (timed) seq_d.phase = PH_MAJOR;
            default:             seq_d.phase = PH_MAJOR;
        endcase
    end

    generate
        if (HOLD_ENABLE) begin : g_level
            assign req = (seq_q.phase == PH_MINOR);
        end else begin : g_start
            assign req = (seq_q.phase == PH_MAJOR) && car;
        end
    endgenerate

    assign phase = seq_q.phase;

    always_ff @(posedge clk) begin
        if (rst) seq_q.phase <= PH_MAJOR;
        else     seq_q       <= seq_d;
    end

    AST_CAR_GRANTS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAJOR && car) |=> (phase == PH_MINOR)); // R3
    AST_MAJOR_WAITS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MAJOR && !car) |=> (phase == PH_MAJOR)); // R4
    AST_MINOR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MINOR && !timed) |=> (phase == PH_MINOR)); // R6
    AST_MINOR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MINOR && timed) |=> (phase == PH_MAJOR)); // R5

endmodule

// File: rtl/tlc_lamp_map.sv
module tlc_lamp_map
    import tlc_pkg::*;
(
    input  phase_t      phase,
    output logic [1:0]  major_lamp,
    output logic [1:0]  minor_lamp
);
    always_comb begin
        major_lamp = (phase == PH_MAJOR) ? LAMP_GREEN : LAMP_RED;
        minor_lamp = (phase == PH_MINOR) ? LAMP_GREEN : LAMP_RED;
    end
endmodule

// File: rtl/tlc_junction.sv
module tlc_junction
    import tlc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter bit HOLD_ENABLE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       car_waiting,
    output logic [1:0] major_lamp,
    output logic [1:0] minor_lamp
);
    logic   req;
    logic   timed;
    phase_t phase;

    tlc_sequencer #(.HOLD_ENABLE(HOLD_ENABLE)) seq_i (
        .clk   (clk),
        .rst   (rst),
        .car   (car_waiting),
        .timed (timed),
        .req   (req),
        .phase (phase)
    );

    tlc_interval_timer #(.CNT_W(CNT_W), .HOLD_ENABLE(HOLD_ENABLE)) tmr_i (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .timed (timed)
    );

    tlc_lamp_map lamp_i (
        .phase      (phase),
        .major_lamp (major_lamp),
        .minor_lamp (minor_lamp)
    );

    AST_ONE_GREEN: assert property (@(posedge clk) disable iff (rst)
        $onehot({major_lamp == LAMP_GREEN, minor_lamp == LAMP_GREEN})); // R2
    AST_RESET_MAJOR: assert property (@(posedge clk)
        rst |=> (major_lamp == LAMP_GREEN && minor_lamp == LAMP_RED)); // R1
    AST_TIMED_ONLY_MINOR: assert property (@(posedge clk) disable iff (rst)
        timed |-> (phase == PH_MINOR)); // R5

endmodule

// File: tb/tlc_junction_tb_top.sv
module tlc_junction_tb_top;
    localparam int CNT_W  = 4;
    localparam int PERIOD = 2 ** CNT_W;
    localparam logic [1:0] GRN = 2'b10;
    localparam logic [1:0] RED = 2'b01;

    // Stimulus table: idle cycles before the request, cycles the sensor is held.
    localparam int ROWS = 5;
    localparam int IDLE_T [ROWS] = '{0, 3, 5, 2, 7};
    localparam int HOLD_T [ROWS] = '{1, 1, 4, PERIOD, 9};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car = 1'b0;
    logic [1:0] maj_p, min_p, maj_h, min_h;
    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlc_junction #(.CNT_W(CNT_W), .HOLD_ENABLE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .car_waiting(car),
        .major_lamp(maj_p), .minor_lamp(min_p));

    tlc_junction #(.CNT_W(CNT_W), .HOLD_ENABLE(1'b1)) dut_en_i (
        .clk(clk), .rst(rst), .car_waiting(car),
        .major_lamp(maj_h), .minor_lamp(min_h));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lamps of both copies must agree and match the expected green road.
    task automatic check_lamps(input bit minor_green, input string req);
        logic [1:0] em, en;
        em = minor_green ? RED : GRN;
        en = minor_green ? GRN : RED;
        check(maj_p == em && min_p == en, req, {maj_p, min_p}, {em, en});
        check(maj_h == maj_p && min_h == min_p, "R8", {maj_h, min_h}, {maj_p, min_p});
    endtask

    // Issue a request and measure the minor-green run length in cycles.
    task automatic serve(input int hold, output int run);
        run = 0;
        car = 1'b1;
        for (int k = 1; k <= 4 * PERIOD; k++) begin
            @(negedge clk);
            if (min_p != GRN) break;
            run++;
            if (k >= hold) car = 1'b0;
        end
        car = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int run;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_lamps(1'b0, "R1");

        // R4: no request keeps major green.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check_lamps(1'b0, "R4");
        end

        // Table walk: R3 grant, R5 exact length, R6 sensor ignored during minor.
        for (int r = 0; r < ROWS; r++) begin
            for (int i = 0; i < IDLE_T[r]; i++) begin
                @(negedge clk);
                check_lamps(1'b0, "R4");
            end
            car = 1'b1;
            @(negedge clk);
            check_lamps(1'b1, "R3");
            serve(HOLD_T[r] - 1, run);
            check(run + 1 == PERIOD, "R6", run + 1, PERIOD);
            check_lamps(1'b0, "R5");
        end

        // R7: sensor held high across return gives a one-cycle major phase.
        car = 1'b1;
        @(negedge clk);
        serve(4 * PERIOD, run);
        check(run + 1 == PERIOD, "R5", run + 1, PERIOD);
        check_lamps(1'b0, "R7");
        car = 1'b1;
        @(negedge clk);
        check_lamps(1'b1, "R7");
        serve(1, run);
        check(run + 1 == PERIOD, "R7", run + 1, PERIOD);

        // R9: reset in the middle of minor green.
        car = 1'b1;
        @(negedge clk);
        car = 1'b0;
        repeat (5) @(negedge clk);
        check_lamps(1'b1, "R9");
        rst = 1'b1;
        @(negedge clk);
        check_lamps(1'b0, "R9");
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_lamps(1'b0, "R1");
        end
        car = 1'b1;
        @(negedge clk);
        serve(1, run);
        check(run + 1 == PERIOD, "R9", run + 1, PERIOD);
        check_lamps(1'b0, "R2");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule